// File: doc/BRIEF.md
# ATA Task-File Register Block with Status Sequencing

This block is the device-side register file of a parallel ATA drive as seen through an eight-offset host I/O window. The host writes task-file bytes and a command. It reads back the task file, an error register, a status byte and data words. The block keeps the status byte and an interrupt request line. It sequences both for three command classes: the identify data-in transfer, the cache flush, and the two DMA transfer commands.

The medium itself sits outside the block. Flush and DMA commands go to a backend through a request level. That level stays up until the backend returns a one-cycle done pulse, optionally with an error flag, and the block then completes the command. Identify data is produced inside the block from parameters: a 20-character serial string, an 8-character firmware string and a sector capacity. It is returned one 16-bit word per data read.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status reads 0x40 (DRDY only), the interrupt is low, no backend request is active, and offsets 1 to 6 read as zero.
- R2: Writes to offsets 2 (sector count), 3, 4, 5 (LBA bits 7:0, 15:8, 23:16) and 6 (device; bit 4 picks device 1, bit 6 picks LBA mode) read back unchanged in bits 7:0 with bits 15:8 zero. Offset 1 reads the error register (bit 2 = abort), and writes to offset 1 or offset 0 change nothing.
- R3: With device register bit 4 set, reads of offsets 7 and 0 return zero and have no side effect (interrupt kept, no word consumed), and command writes are ignored.
- R4: Any opcode other than 0xC8, 0xCA, 0xE7, 0xEC sets status to 0x41 and the error register to 0x04 and raises the interrupt, one clock edge after the write.
- R5: Opcode 0xEC makes status 0x48 (DRDY and DRQ, BSY/DF/ERR clear) and raises the interrupt; each data read at offset 0 returns the current word and advances to the next.
- R6: Identify word 85 is 0x0020 (write cache enabled), word 49 is 0x0300, words 60/61 are the low/high halves of the capacity, words 10 to 19 hold the serial and words 23 to 26 the firmware string (two characters per word, first character in bits 15:8), and every other word is zero.
- R7: The 256th data read drops status to 0x40 without an interrupt; data reads outside a transfer return zero.
- R8: Opcode 0xE7 makes status 0xC0 and asserts the backend request with operation code 0; a done pulse ends the request, sets status 0x40 and raises the interrupt.
- R9: Opcodes 0xC8/0xCA assert the backend request with operation code 1/2 and present the LBA and sector count; a done pulse with the error flag sets status 0x41 and error 0x04.
- R10: Command writes while BSY is set are ignored: status, error register and backend operation stay unchanged.
- R11: A status read clears the interrupt; if a completion event arrives in the same cycle, the interrupt stays set.
- R12: The interrupt rises only on a command write or a backend completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_addr_i | input | 3 | Register offset |
| acc_wr_i | input | 1 | Write strobe, one cycle |
| acc_rd_i | input | 1 | Read strobe, one cycle (carries read side effects) |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 16 | Read data for the addressed offset, combinational |
| irq_o | output | 1 | Interrupt request |
| be_req_o | output | 1 | Backend request, held until done |
| be_op_o | output | 2 | Backend operation: 0 flush, 1 DMA read, 2 DMA write |
| be_lba_o | output | 24 | Task-file LBA to the backend |
| be_cnt_o | output | 8 | Task-file sector count to the backend |
| be_done_i | input | 1 | Backend completion pulse |
| be_err_i | input | 1 | Backend error flag, valid with done |

## Verification
Every register write, strobe and done pulse takes effect at the first rising edge it is held across. Status, error register, interrupt and backend outputs are therefore due one edge after the stimulus. Read data is a combinational function of the address and of that registered state. The bench drives each stimulus at a falling edge, holds it over exactly one rising edge, and samples at the next falling edge. Read data is sampled 1 ns after the address is set, so no result is taken on the edge that produces it.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_ERR  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_LBA0 = 3'd3;
  localparam logic [2:0] OFS_LBA1 = 3'd4;
  localparam logic [2:0] OFS_LBA2 = 3'd5;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_STC  = 3'd7;

  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DF   = 8'h20;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;

  localparam int unsigned DEV_SEL_BIT = 4;
  localparam logic [7:0]  ERRR_ABRT   = 8'h04;

  localparam logic [7:0] OPC_RD_DMA = 8'hC8;
  localparam logic [7:0] OPC_WR_DMA = 8'hCA;
  localparam logic [7:0] OPC_FLUSH  = 8'hE7;
  localparam logic [7:0] OPC_IDENT  = 8'hEC;

  typedef enum logic [1:0] {
    BE_FLUSH = 2'd0,
    BE_RD    = 2'd1,
    BE_WR    = 2'd2
  } be_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUSY = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
  parameter int unsigned FIRST = 2,
  parameter int unsigned NUM   = 5,
  parameter int unsigned AW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM*8-1:0]  file_o
);
  logic [NUM*8-1:0] file_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      file_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM; i++) begin
        if (addr_i == AW'(FIRST + i)) file_q[i*8 +: 8] <= wdata_i;
      end
    end
  end

  assign file_o = file_q;
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int unsigned  IDENT_WORDS = 256,
  parameter logic [159:0] SERIAL_STR  = "0123456789ABCDEFGHIJ",
  parameter logic [63:0]  FW_STR      = "REV-01.2",
  parameter logic [31:0]  SECTORS     = 32'h0002_0000,
  localparam int unsigned IW          = $clog2(IDENT_WORDS)
) (
  input  logic [IW-1:0] idx_i,
  output logic [15:0]   word_o
);
  localparam int unsigned SER_BASE  = 10;
  localparam int unsigned SER_WORDS = 10;
  localparam int unsigned FW_BASE   = 23;
  localparam int unsigned FW_WORDS  = 4;
  localparam int unsigned CAPS_WORD = 49;
  localparam int unsigned SIZE_LO   = 60;
  localparam int unsigned SIZE_HI   = 61;
  localparam int unsigned CACHE_WORD = 85;
  localparam int unsigned SER_BITS  = SER_WORDS * 16;
  localparam int unsigned FW_BITS   = FW_WORDS * 16;

  int unsigned k;

  always_comb begin
    k      = 32'(idx_i);
    word_o = '0;
    if (k >= SER_BASE && k < SER_BASE + SER_WORDS) begin
      word_o = SERIAL_STR[SER_BITS - 1 - 16*(k - SER_BASE) -: 16];
    end else if (k >= FW_BASE && k < FW_BASE + FW_WORDS) begin
      word_o = FW_STR[FW_BITS - 1 - 16*(k - FW_BASE) -: 16];
    end else if (k == CAPS_WORD) begin
      word_o = 16'h0300;
    end else if (k == SIZE_LO) begin
      word_o = SECTORS[15:0];
    end else if (k == SIZE_HI) begin
      word_o = SECTORS[31:16];
    end else if (k == CACHE_WORD) begin
      word_o = 16'h0020;
    end
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int unsigned  IDENT_WORDS = 256,
  localparam int unsigned IW          = $clog2(IDENT_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [7:0]    cmd_op_i,
  input  logic          st_rd_i,
  input  logic          data_rd_i,
  input  logic          be_done_i,
  input  logic          be_err_i,
  output logic [7:0]    status_o,
  output logic [7:0]    errreg_o,
  output logic          irq_o,
  output logic          be_req_o,
  output logic [1:0]    be_op_o,
  output logic [IW-1:0] idx_o
);
  phase_e        ph_q, ph_d;
  logic [7:0]    st_q, st_d, er_q, er_d;
  logic          irq_q, irq_d, req_q, req_d, irq_set;
  be_op_e        op_q, op_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    ph_d    = ph_q;
    st_d    = st_q;
    er_d    = er_q;
    req_d   = req_q;
    op_d    = op_q;
    idx_d   = idx_q;
    irq_set = 1'b0;
    if (ph_q == PH_BUSY) begin
      // backend owns the command; new commands dropped
      if (be_done_i) begin
        ph_d    = PH_IDLE;
        req_d   = 1'b0;
        st_d    = be_err_i ? (ST_DRDY | ST_ERR) : ST_DRDY;
        er_d    = be_err_i ? ERRR_ABRT : 8'h00;
        irq_set = 1'b1;
      end
    end else if (cmd_we_i) begin
      er_d = 8'h00;
      case (cmd_op_i)
        OPC_IDENT: begin
          ph_d    = PH_DATA;
          st_d    = ST_DRDY | ST_DRQ;
          idx_d   = '0;
          irq_set = 1'b1;
        end
        OPC_FLUSH, OPC_RD_DMA, OPC_WR_DMA: begin
          ph_d  = PH_BUSY;
          st_d  = ST_BSY | ST_DRDY;
          req_d = 1'b1;
          op_d  = (cmd_op_i == OPC_FLUSH)  ? BE_FLUSH :
                  (cmd_op_i == OPC_RD_DMA) ? BE_RD : BE_WR;
        end
        default: begin
          ph_d    = PH_IDLE;
          st_d    = ST_DRDY | ST_ERR;
          er_d    = ERRR_ABRT;
          irq_set = 1'b1;
        end
      endcase
    end else if (ph_q == PH_DATA && data_rd_i) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IW'(IDENT_WORDS - 1)) begin
        ph_d  = PH_IDLE;
        st_d  = ST_DRDY;
        idx_d = '0;
      end
    end
    irq_d = irq_set | (irq_q & ~st_rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      st_q  <= ST_DRDY;
      er_q  <= 8'h00;
      irq_q <= 1'b0;
      req_q <= 1'b0;
      op_q  <= BE_FLUSH;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      st_q  <= st_d;
      er_q  <= er_d;
      irq_q <= irq_d;
      req_q <= req_d;
      op_q  <= op_d;
      idx_q <= idx_d;
    end
  end

  assign status_o = st_q;
  assign errreg_o = er_q;
  assign irq_o    = irq_q;
  assign be_req_o = req_q;
  assign be_op_o  = op_q;
  assign idx_o    = idx_q;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int unsigned  IDENT_WORDS = 256,
  parameter logic [159:0] SERIAL_STR  = "0123456789ABCDEFGHIJ",
  parameter logic [63:0]  FW_STR      = "REV-01.2",
  parameter logic [31:0]  SECTORS     = 32'h0002_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  acc_addr_i,
  input  logic        acc_wr_i,
  input  logic        acc_rd_i,
  input  logic [7:0]  acc_wdata_i,
  output logic [15:0] acc_rdata_o,
  output logic        irq_o,
  output logic        be_req_o,
  output logic [1:0]  be_op_o,
  output logic [23:0] be_lba_o,
  output logic [7:0]  be_cnt_o,
  input  logic        be_done_i,
  input  logic        be_err_i
);
  localparam int unsigned IW     = $clog2(IDENT_WORDS);
  localparam int unsigned TF_NUM = 5;

  logic [TF_NUM*8-1:0] tf_w;
  logic [7:0]  cnt_w, dev_w, status_w, errreg_w;
  logic [23:0] lba_w;
  logic        dev1_w, cmd_we_w, st_rd_w, data_rd_w;
  logic [IW-1:0] idx_w;
  logic [15:0] word_w;

  assign cnt_w  = tf_w[7:0];
  assign lba_w  = tf_w[31:8];
  assign dev_w  = tf_w[39:32];
  assign dev1_w = dev_w[DEV_SEL_BIT];

  assign cmd_we_w  = acc_wr_i && acc_addr_i == OFS_STC  && !dev1_w;
  assign st_rd_w   = acc_rd_i && acc_addr_i == OFS_STC  && !dev1_w;
  assign data_rd_w = acc_rd_i && acc_addr_i == OFS_DATA && !dev1_w;

  ata_tf_regs #(.FIRST(OFS_CNT), .NUM(TF_NUM), .AW(3)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc_wr_i),
    .addr_i  (acc_addr_i),
    .wdata_i (acc_wdata_i),
    .file_o  (tf_w)
  );

  ata_tf_seq #(.IDENT_WORDS(IDENT_WORDS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_w),
    .cmd_op_i  (acc_wdata_i),
    .st_rd_i   (st_rd_w),
    .data_rd_i (data_rd_w),
    .be_done_i (be_done_i),
    .be_err_i  (be_err_i),
    .status_o  (status_w),
    .errreg_o  (errreg_w),
    .irq_o     (irq_o),
    .be_req_o  (be_req_o),
    .be_op_o   (be_op_o),
    .idx_o     (idx_w)
  );

  ata_tf_ident #(
    .IDENT_WORDS (IDENT_WORDS),
    .SERIAL_STR  (SERIAL_STR),
    .FW_STR      (FW_STR),
    .SECTORS     (SECTORS)
  ) u_ident (
    .idx_i  (idx_w),
    .word_o (word_w)
  );

  always_comb begin
    acc_rdata_o = '0;
    unique case (acc_addr_i)
      OFS_DATA: acc_rdata_o = (!dev1_w && (status_w & ST_DRQ) != 8'h00) ? word_w : 16'h0000;
      OFS_ERR:  acc_rdata_o = {8'h00, errreg_w};
      OFS_CNT:  acc_rdata_o = {8'h00, cnt_w};
      OFS_LBA0: acc_rdata_o = {8'h00, lba_w[7:0]};
      OFS_LBA1: acc_rdata_o = {8'h00, lba_w[15:8]};
      OFS_LBA2: acc_rdata_o = {8'h00, lba_w[23:16]};
      OFS_DEV:  acc_rdata_o = {8'h00, dev_w};
      OFS_STC:  acc_rdata_o = dev1_w ? 16'h0000 : {8'h00, status_w};
      default:  acc_rdata_o = '0;
    endcase
  end

  assign be_lba_o = lba_w;
  assign be_cnt_o = cnt_w;
endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic       st_rd_i,
  input logic       be_done_i,
  input logic       be_req_i,
  input logic [1:0] be_op_i,
  input logic [7:0] status_i,
  input logic       irq_i
);
  AST_REQ_IMPLIES_BSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_i |-> status_i[7]);  // R8

  AST_DONE_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_i && be_done_i) |=> (!status_i[7] && !be_req_i && irq_i));  // R9

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[7] && !be_done_i) |=> (status_i[7] && $stable(be_op_i)));  // R10

  AST_STATUS_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd_i && !cmd_we_i && !(be_req_i && be_done_i)) |=> !irq_i);  // R11

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(cmd_we_i || (be_req_i && be_done_i)));  // R12

  AST_NO_BSY_WITH_DRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_i[7] && status_i[3]));  // R5
endmodule

bind ata_taskfile ata_tf_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_we_i  (cmd_we_w),
  .st_rd_i   (st_rd_w),
  .be_done_i (be_done_i),
  .be_req_i  (be_req_o),
  .be_op_i   (be_op_o),
  .status_i  (status_w),
  .irq_i     (irq_o)
);

// File: tb/sim_ata_taskfile.sv
`timescale 1ns/1ps
module sim_ata_taskfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        irq, be_req, be_done = 1'b0, be_err = 1'b0;
  logic [1:0]  be_op;
  logic [23:0] be_lba;
  logic [7:0]  be_cnt;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  string ser_s = "0123456789ABCDEFGHIJ";
  string fw_s  = "REV-01.2";
  localparam logic [31:0] CAP = 32'h0002_0000;

  always #2 clk = ~clk;

  ata_taskfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_addr_i(acc_addr), .acc_wr_i(acc_wr),
    .acc_rd_i(acc_rd), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .irq_o(irq), .be_req_o(be_req), .be_op_o(be_op), .be_lba_o(be_lba),
    .be_cnt_o(be_cnt), .be_done_i(be_done), .be_err_i(be_err)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    acc_addr = a;
    #1 d = acc_rdata;
  endtask

  task automatic done_pulse(logic e);
    @(negedge clk);
    be_done = 1'b1; be_err = e;
    @(negedge clk);
    be_done = 1'b0; be_err = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(int i);
    if (i >= 10 && i < 20) return {ser_s[2*(i-10)], ser_s[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {fw_s[2*(i-23)], fw_s[2*(i-23)+1]};
    if (i == 49) return 16'h0300;
    if (i == 60) return CAP[15:0];
    if (i == 61) return CAP[31:16];
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      summary();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd7, d); chk("R1 status", d, 32'h40);
    chk("R1 irq", irq, 0);
    chk("R1 be_req", be_req, 0);
    for (int a = 1; a <= 6; a++) begin
      peek(3'(a), d); chk("R1 taskfile", d, 0);
    end

    // R2 readback sweep
    for (int a = 2; a <= 5; a++) begin
      for (int v = 0; v < 256; v += 37) begin
        wr(3'(a), 8'(v)); peek(3'(a), d); chk("R2 readback", d, 32'(v));
      end
    end
    wr(3'd2, 8'h05); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33);
    wr(3'd6, 8'h40); peek(3'd6, d); chk("R2 device", d, 32'h40);
    wr(3'd1, 8'hFF); peek(3'd1, d); chk("R2 feature write ignored", d, 0);
    wr(3'd0, 8'hFF); peek(3'd7, d); chk("R2 data write ignored", d, 32'h40);

    // R4 unsupported opcodes, R11 status read clears irq
    for (int op = 0; op < 256; op++) begin
      if (op == 'hC8 || op == 'hCA || op == 'hE7 || op == 'hEC) continue;
      wr(3'd7, 8'(op));
      chk("R4 irq", irq, 1);
      peek(3'd1, d); chk("R4 error", d, 32'h04);
      rd(3'd7, d); chk("R4 status", d, 32'h41);
      chk("R11 cleared", irq, 0);
    end

    // R3 device 1 selected
    wr(3'd7, 8'h00); chk("R3 pre irq", irq, 1);
    wr(3'd6, 8'h50);
    rd(3'd7, d); chk("R3 status zero", d, 0);
    chk("R3 irq kept", irq, 1);
    wr(3'd7, 8'hE7); chk("R3 cmd ignored", be_req, 0);
    wr(3'd6, 8'h40);
    peek(3'd7, d); chk("R3 status unchanged", d, 32'h41);
    rd(3'd7, d);

    // R8 flush, R10 ignore while busy
    wr(3'd7, 8'hE7);
    peek(3'd7, d); chk("R8 busy", d, 32'hC0);
    chk("R8 req", be_req, 1); chk("R8 op", be_op, 0); chk("R8 no irq", irq, 0);
    wr(3'd7, 8'hEC); peek(3'd7, d); chk("R10 ident ignored", d, 32'hC0);
    wr(3'd7, 8'h00); peek(3'd7, d); chk("R10 bad op ignored", d, 32'hC0);
    peek(3'd1, d); chk("R10 error kept", d, 0);
    chk("R10 op kept", be_op, 0); chk("R10 no irq", irq, 0);
    repeat (5) @(negedge clk);
    chk("R8 req held", be_req, 1);
    done_pulse(1'b0);
    peek(3'd7, d); chk("R8 done status", d, 32'h40);
    chk("R8 irq", irq, 1); chk("R8 req dropped", be_req, 0);
    rd(3'd7, d);
    done_pulse(1'b0); chk("R12 stray done no irq", irq, 0);

    // R9 DMA read with error
    wr(3'd7, 8'hC8);
    chk("R9 op read", be_op, 1); chk("R9 lba", be_lba, 32'h332211);
    chk("R9 cnt", be_cnt, 5); chk("R9 req", be_req, 1);
    done_pulse(1'b1);
    peek(3'd7, d); chk("R9 err status", d, 32'h41);
    peek(3'd1, d); chk("R9 err reg", d, 32'h04);
    chk("R9 irq", irq, 1);
    rd(3'd7, d);

    // R9 DMA write, R11 same-cycle set wins
    wr(3'd7, 8'hCA);
    chk("R9 op write", be_op, 2);
    peek(3'd1, d); chk("R9 err cleared", d, 0);
    @(negedge clk);
    be_done = 1'b1; acc_addr = 3'd7; acc_rd = 1'b1;
    @(negedge clk);
    be_done = 1'b0; acc_rd = 1'b0;
    chk("R11 set wins", irq, 1);
    peek(3'd7, d); chk("R9 ok status", d, 32'h40);
    rd(3'd7, d); chk("R11 clear", irq, 0);

    // R5 R6 R7 identify
    rd(3'd0, d); chk("R7 idle data", d, 0);
    wr(3'd7, 8'hEC);
    chk("R5 irq", irq, 1);
    rd(3'd7, d); chk("R5 status", d, 32'h48);
    for (int i = 0; i < 256; i++) begin
      peek(3'd7, d); chk("R5 status in transfer", d, 32'h48);
      rd(3'd0, d); chk("R6 word", d, 32'(exp_word(i)));
    end
    peek(3'd7, d); chk("R7 end status", d, 32'h40);
    chk("R7 no irq", irq, 0);
    rd(3'd0, d); chk("R7 data after end", d, 0);

    done_flag = 1;
    summary();
  end
endmodule